// File: doc/BRIEF.md
# Status Summary Byte with Service Request

This block forms the eight-bit status summary byte of an instrument's remote control interface. Five live flags from elsewhere in the instrument feed it: the error queue is non-empty, the response queue is non-empty, and the summaries of the standard event group, the questionable group and the operation group. None of these bits is stored. Each bit of the byte follows its source flag directly, so when a lower register is cleared the matching bit drops at once.

A writable enable mask picks which summary bits may ask for service. The master summary bit, at position 6, is the OR of the enabled bits. A one-cycle service-request pulse marks each rising edge of that master bit. A clear-status strobe cancels a pending pulse and re-arms the edge detector. The enable mask keeps its value through the strobe, so a condition that is still enabled and active asks for service again.

Top module: `status_summary_byte`

## Requirements
- R1: Bits 0 and 1 of `stb_byte` always read 0, whatever the inputs and the mask hold.
- R2: Bit 2 of `stb_byte` equals `err_pending` in the same cycle.
- R3: Bit 3 equals `ques_sum`, bit 5 equals `evt_sum` and bit 7 equals `oper_sum`, all in the same cycle.
- R4: Bit 4 equals `resp_pending`. It falls in the same cycle that the response queue empties.
- R5: No summary bit is latched. When a source flag drops, its bit drops with no clock edge needed.
- R6: Bit 6 is 1 exactly when some bit of the byte other than bit 6 is 1 and its mask bit is also 1. Mask bit 6 has no effect.
- R7: A write with `mask_we` high stores `mask_wdata` at the clock edge, and `mask_q` shows it. The mask resets to 0. While the mask is 0, bit 6 and `srq` stay 0.
- R8: `srq` is high for exactly one cycle. That cycle comes right after the clock edge that samples bit 6 at 1, where bit 6 was 0 at the edge before.
- R9: `clr_stb` forces `srq` low at the next edge, clears the edge history and leaves the mask unchanged. If bit 6 is still 1, `srq` pulses one cycle later.
- R10: With only the questionable and response flags active and a zero mask, the byte reads 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_pending | input | 1 | Error queue holds at least one entry |
| resp_pending | input | 1 | Response queue holds at least one entry |
| evt_sum | input | 1 | Enabled summary of the standard event group |
| ques_sum | input | 1 | Enabled summary of the questionable group |
| oper_sum | input | 1 | Summary of the operation group |
| mask_we | input | 1 | Write strobe for the enable mask |
| mask_wdata | input | 8 | New enable mask value |
| clr_stb | input | 1 | Clear-status strobe |
| stb_byte | output | 8 | Combinational status summary byte |
| mask_q | output | 8 | Current enable mask |
| srq | output | 1 | One-cycle service-request pulse |

## Verification
The byte, including the master bit, is combinational in both the inputs and the stored mask. The bench therefore checks it one time unit after it changes a flag, with no clock edge in between. A change to the mask appears in the byte and in `mask_q` after the edge that stores it. `srq` takes one register stage, so it is sampled just after the edge that follows the rise of the master bit, and again one edge later to confirm that it has fallen. After a clear strobe, the bench checks `srq` low after the strobe's edge and high after the edge that follows it.

// File: rtl/status_summary_byte.sv
module status_summary_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_pending,
  input  logic       resp_pending,
  input  logic       evt_sum,
  input  logic       ques_sum,
  input  logic       oper_sum,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  input  logic       clr_stb,
  output logic [7:0] stb_byte,
  output logic [7:0] mask_q,
  output logic       srq
);
  localparam int MSS_BIT = 6;

  logic [7:0] raw_bits;
  logic       master;
  logic       master_q;

  assign raw_bits = {oper_sum, 1'b0, evt_sum, resp_pending, ques_sum, err_pending, 2'b00};
  assign master   = |(raw_bits & mask_q & ~(8'd1 << MSS_BIT));
  assign stb_byte = raw_bits | ({7'd0, master} << MSS_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 8'd0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      srq      <= 1'b0;
    end else if (clr_stb) begin
      master_q <= 1'b0;
      srq      <= 1'b0;
    end else begin
      master_q <= master;
      srq      <= master & ~master_q;
    end
  end

  a_r7_mask_store: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> mask_q == $past(mask_wdata));

  a_r7_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == 8'd0) |-> !stb_byte[MSS_BIT]);

  a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    srq |=> !srq);

  a_r8_pulse_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    srq |-> $past(stb_byte[MSS_BIT]));

  a_r9_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> !srq);

  a_r9_clear_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !mask_we) |=> $stable(mask_q));

  always_comb a_r1_low_bits_zero: assert (stb_byte[1:0] == 2'b00 || !rst_n);
endmodule

// File: tb/status_summary_byte_tb.sv
module status_summary_byte_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_pending = 0, resp_pending = 0, evt_sum = 0, ques_sum = 0, oper_sum = 0;
  logic mask_we = 0, clr_stb = 0;
  logic [7:0] mask_wdata = 8'd0;
  logic [7:0] stb_byte, mask_q;
  logic srq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  status_summary_byte u_dut (
    .clk(clk), .rst_n(rst_n), .err_pending(err_pending), .resp_pending(resp_pending),
    .evt_sum(evt_sum), .ques_sum(ques_sum), .oper_sum(oper_sum),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_stb(clr_stb),
    .stb_byte(stb_byte), .mask_q(mask_q), .srq(srq)
  );

  // {mask[7:0], err, resp, evt, ques, oper, expected[7:0]}
  localparam logic [20:0] VEC [12] = '{
    {8'h00, 5'b00000, 8'h00},  // R1 idle
    {8'h00, 5'b01010, 8'h18},  // R10 ques + resp = 24
    {8'h00, 5'b10000, 8'h04},  // R2
    {8'h04, 5'b10000, 8'h44},  // R6 err enabled
    {8'h40, 5'b11111, 8'hBC},  // R6 mask bit 6 alone ignored
    {8'hFF, 5'b11111, 8'hFC},  // R3 R6 all
    {8'h80, 5'b00001, 8'hC0},  // R3 oper enabled
    {8'h20, 5'b00100, 8'h60},  // R3 evt enabled
    {8'h08, 5'b01000, 8'h10},  // R4 resp, ques enabled only
    {8'h10, 5'b01000, 8'h50},  // R4 R6 resp enabled
    {8'h03, 5'b11111, 8'hBC},  // R1 low mask bits no effect
    {8'hFF, 5'b00000, 8'h00}   // R6 nothing active
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic write_mask(input logic [7:0] m);
    mask_we = 1'b1;
    mask_wdata = m;
    step();
    mask_we = 1'b0;
  endtask

  task automatic set_flags(input logic [4:0] f);
    {err_pending, resp_pending, evt_sum, ques_sum, oper_sum} = f;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step();
    step();
    chk("R7 reset mask", mask_q, 8'h00);
    chk("R1 reset byte", stb_byte, 8'h00);
    chk("R8 reset srq", {7'd0, srq}, 8'h00);
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 12; i++) begin
      write_mask(VEC[i][20:13]);
      chk("R7 mask readback", mask_q, VEC[i][20:13]);
      set_flags(VEC[i][12:8]);
      #1;
      chk("R1-R6/R10 table", stb_byte, VEC[i][7:0]);
      set_flags(5'b00000);
      step();
    end

    // R4 R5: bits drop without a clock edge
    write_mask(8'h00);
    set_flags(5'b01000);
    #1;
    chk("R4 resp set", stb_byte, 8'h10);
    set_flags(5'b00000);
    #1;
    chk("R4 resp drops same cycle", stb_byte, 8'h00);
    set_flags(5'b00100);
    #1;
    chk("R5 evt set", stb_byte, 8'h20);
    set_flags(5'b00000);
    #1;
    chk("R5 evt unlatched", stb_byte, 8'h00);

    // R7: a zero mask gives no request
    set_flags(5'b11111);
    step();
    chk("R7 zero mask no srq", {7'd0, srq}, 8'h00);
    step();
    chk("R7 zero mask no srq later", {7'd0, srq}, 8'h00);
    set_flags(5'b00000);
    step();

    // R8: a one-cycle pulse on the rise of bit 6
    write_mask(8'h04);
    step();
    err_pending = 1'b1;
    step();
    chk("R8 srq pulse high", {7'd0, srq}, 8'h01);
    step();
    chk("R8 srq pulse one cycle", {7'd0, srq}, 8'h00);
    step();
    chk("R8 srq stays low while held", {7'd0, srq}, 8'h00);

    // R9: clear re-arms while the condition stays active
    clr_stb = 1'b1;
    step();
    clr_stb = 1'b0;
    chk("R9 srq low after clear", {7'd0, srq}, 8'h00);
    chk("R9 mask kept", mask_q, 8'h04);
    step();
    chk("R9 re-request after clear", {7'd0, srq}, 8'h01);
    step();
    chk("R9 re-request one cycle", {7'd0, srq}, 8'h00);

    // R9: a clear on the pulse's own edge suppresses it
    err_pending = 1'b0;
    step();
    step();
    err_pending = 1'b1;
    clr_stb = 1'b1;
    step();
    clr_stb = 1'b0;
    chk("R9 clear suppresses pulse", {7'd0, srq}, 8'h00);
    step();
    chk("R9 pulse after suppressed edge", {7'd0, srq}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule